// File: doc/BRIEF.md
# Indexed Performance Counter Bank

This block is a bank of wide event counters reached through one small register port. A single index register opens a window onto one counter at a time. Through that window software sets the counter's countable-condition number, presets its value in two halves, and reads a coherent copy of it in two halves. Each counter adds one on every clock in which the global enable is on and the event line picked by its condition number is high. Condition number 0 never fires, so writing 0 is how software stops a counter.

Reading a wide running counter as two 32-bit halves can tear if the low half wraps between the two reads. To avoid that, software sets a self-clearing capture bit in the control register. On the next clock the windowed counter's full value is copied into one snapshot register, and software then reads that register's two halves at leisure. A read-only build word tells software that the unit exists, how many counters it has and how wide they are. The bank raises no interrupts.

Top module: `perfctr_bank`

## Requirements
- R1: After reset the control, index, condition, count and snapshot registers all read 0.
- R2: Register offsets on `reg_addr` are: 0 control, 1 index, 2 condition, 3 count low, 4 count high, 5 snapshot low, 6 snapshot high, 7 build. The index register (8 bits) selects the counter that offsets 2 to 6 refer to, and it reads back as written.
- R3: A counter adds 1 at a clock edge when control bit 0 is 1, its condition number c is nonzero and `ev_in[c]` is high. `ev_in[0]` never causes a count.
- R4: A counter whose condition number is 0 keeps its value whatever the event inputs do.
- R5: While control bit 0 is 0, no counter changes except through a write of one of its count halves.
- R6: A write to count low sets counter bits 31:0. A write to count high sets bits W-1:32 from the low bits of the data. The other half keeps its value. If such a write and an increment fall in the same cycle, the written value is kept and the increment is lost.
- R7: A counter has W = 32 + 16*CTR_SEL bits and wraps from all ones to 0.
- R8: Writing the control register with bit 1 set makes bit 1 read 1 for one cycle. At the next edge the windowed counter's value is copied into the snapshot register, which is read at offsets 5 and 6, and bit 1 then reads 0.
- R9: Control bits 31:16 are stored as written and read back. Control bits 15:2 read 0.
- R10: While the index is at or above NUM_CTR, offsets 2 to 6 read 0 and writes to offsets 2 to 4 change nothing.
- R11: The build word reads bits 7:0 = 1 (unit present), bits 15:8 = NUM_CTR, bits 17:16 = CTR_SEL, and 0 elsewhere. Writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| ev_in | input | NUM_COND | Event lines indexed by condition number |

## Verification
The hardest case to reach is a counter sitting just below the 32-bit boundary while it is running. Software captures it and then reads the two snapshot halves on later cycles, while the live low half has already wrapped and carried into the high half. The stimulus gets there directly: it presets the low half to just under all ones, holds the selected event line high with counting enabled, requests a capture, and then reads the live halves and the snapshot halves on the following cycles. A long stretch of seeded random register traffic follows. It mixes index values that fall outside the bank, same-cycle writes and increments, and random event patterns, including pulses on line 0. Every read is compared against a cycle model kept in the bench.

// File: rtl/perfctr_pkg.sv
package perfctr_pkg;

  localparam int REG_AW = 3;
  localparam int DW     = 32;
  localparam int IDX_W  = 8;
  localparam logic [7:0] UNIT_VERSION = 8'h01;

  typedef enum logic [REG_AW-1:0] {
    RA_CTRL    = 3'd0,
    RA_INDEX   = 3'd1,
    RA_COND    = 3'd2,
    RA_CNT_LO  = 3'd3,
    RA_CNT_HI  = 3'd4,
    RA_SNAP_LO = 3'd5,
    RA_SNAP_HI = 3'd6,
    RA_BUILD   = 3'd7
  } reg_addr_e;

  // counter width from the width-select code
  function automatic int ctr_width(input int sel);
    return 32 + 16 * sel;
  endfunction

  // read-only description word
  function automatic logic [DW-1:0] build_word(input int n_ctr, input int sel);
    logic [DW-1:0] w;
    w        = '0;
    w[7:0]   = UNIT_VERSION;
    w[15:8]  = 8'(n_ctr);
    w[17:16] = 2'(sel);
    return w;
  endfunction

endpackage

// File: rtl/perfctr_counter.sv
module perfctr_counter #(
  parameter int NUM_COND = 8,
  parameter int CTR_W    = 48
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        en_i,
  input  logic [NUM_COND-1:0]         ev_i,
  input  logic                        cfg_we,
  input  logic                        lo_we,
  input  logic                        hi_we,
  input  logic [31:0]                 wdata,
  output logic [CTR_W-1:0]            cnt_o,
  output logic [$clog2(NUM_COND)-1:0] cfg_o,
  output logic                        inc_o
);

  localparam int COND_W = $clog2(NUM_COND);
  localparam int HI_W   = CTR_W - 32;

  logic [COND_W-1:0] cfg_q;
  logic [CTR_W-1:0]  cnt_q;
  logic              inc_hit;
  logic              wr_any;

  // condition 0 is the never-firing condition
  function automatic logic cond_fires(input logic [NUM_COND-1:0] ev,
                                      input logic [COND_W-1:0]   sel);
    logic [NUM_COND-1:0] live;
    live    = ev;
    live[0] = 1'b0;
    if (sel == '0 || int'(sel) >= NUM_COND) return 1'b0;
    return live[sel];
  endfunction

  function automatic logic [CTR_W-1:0] bump(input logic [CTR_W-1:0] v);
    return v + CTR_W'(1);
  endfunction

  assign inc_hit = en_i && cond_fires(ev_i, cfg_q);
  assign wr_any  = lo_we || hi_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      cnt_q <= '0;
    end else begin
      if (cfg_we) cfg_q <= wdata[COND_W-1:0];
      if (wr_any) begin
        if (lo_we) cnt_q[31:0]      <= wdata;
        if (hi_we) cnt_q[CTR_W-1:32] <= wdata[HI_W-1:0];
      end else if (inc_hit) begin
        cnt_q <= bump(cnt_q);
      end
    end
  end

  assign cnt_o = cnt_q;
  assign cfg_o = cfg_q;
  assign inc_o = inc_hit;

  // R4: never condition freezes the counter
  p_never_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q == '0 && !wr_any) |=> $stable(cnt_q));

  // R5: disabled bank freezes the counter
  p_disabled_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !wr_any) |=> $stable(cnt_q));

  // R3 / R7: without a write a counter moves by at most one, modulo its width
  p_single_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_any |=> (CTR_W'(cnt_q - $past(cnt_q)) <= CTR_W'(1)));

  // R6: low-half write wins over a same-cycle increment
  p_write_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lo_we |=> (cnt_q[31:0] == $past(wdata)));

endmodule

// File: rtl/perfctr_ctrl.sv
module perfctr_ctrl
  import perfctr_pkg::*;
#(
  parameter int NUM_CTR = 4,
  parameter int CTR_W   = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_we,
  input  logic             idx_we,
  input  logic [DW-1:0]    wdata,
  input  logic [CTR_W-1:0] sel_cnt,
  output logic             en_o,
  output logic [15:0]      upper_o,
  output logic             snap_pend_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             idx_ok_o,
  output logic [CTR_W-1:0] snap_o
);

  logic             en_q;
  logic [15:0]      upper_q;
  logic             pend_q;
  logic [IDX_W-1:0] idx_q;
  logic [CTR_W-1:0] snap_q;
  logic             snap_fire;

  function automatic logic in_window(input logic [IDX_W-1:0] idx);
    return int'(idx) < NUM_CTR;
  endfunction

  assign snap_fire = pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      upper_q <= '0;
      pend_q  <= 1'b0;
      idx_q   <= '0;
      snap_q  <= '0;
    end else begin
      if (ctrl_we) begin
        en_q    <= wdata[0];
        upper_q <= wdata[31:16];
      end
      pend_q <= ctrl_we && wdata[1];
      if (idx_we)    idx_q  <= wdata[IDX_W-1:0];
      if (snap_fire) snap_q <= sel_cnt;
    end
  end

  assign en_o        = en_q;
  assign upper_o     = upper_q;
  assign snap_pend_o = pend_q;
  assign idx_o       = idx_q;
  assign idx_ok_o    = in_window(idx_q);
  assign snap_o      = snap_q;

  // R8: capture request lasts one cycle unless re-requested
  p_snap_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !ctrl_we) |=> !pend_q);

  // R8: snapshot takes the windowed value seen during the pending cycle
  p_snap_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |=> (snap_q == $past(sel_cnt)));

  // R8: snapshot only moves on a capture
  p_snap_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_q |=> $stable(snap_q));

endmodule

// File: rtl/perfctr_bank.sv
module perfctr_bank
  import perfctr_pkg::*;
#(
  parameter int NUM_CTR  = 4,
  parameter int NUM_COND = 8,
  parameter int CTR_SEL  = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [2:0]          reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  input  logic [NUM_COND-1:0] ev_in
);

  localparam int CTR_W  = ctr_width(CTR_SEL);
  localparam int COND_W = $clog2(NUM_COND);

  reg_addr_e addr;
  logic      wr_ctrl, wr_idx, wr_cfg, wr_lo, wr_hi, win_addr;

  logic             en;
  logic [15:0]      ctrl_upper;
  logic             snap_pend;
  logic [IDX_W-1:0] idx;
  logic             idx_ok;
  logic [CTR_W-1:0] snap_val;

  logic [CTR_W-1:0]                cnt_all [NUM_CTR];
  logic [NUM_CTR-1:0][COND_W-1:0]  cfg_all;
  logic [NUM_CTR-1:0]              inc_all;
  logic [CTR_W-1:0]                sel_cnt;
  logic [COND_W-1:0]               sel_cfg;

  assign addr     = reg_addr_e'(reg_addr);
  assign win_addr = (addr == RA_COND) || (addr == RA_CNT_LO) || (addr == RA_CNT_HI) ||
                    (addr == RA_SNAP_LO) || (addr == RA_SNAP_HI);

  assign wr_ctrl = reg_we && (addr == RA_CTRL);
  assign wr_idx  = reg_we && (addr == RA_INDEX);
  assign wr_cfg  = reg_we && (addr == RA_COND)   && idx_ok;
  assign wr_lo   = reg_we && (addr == RA_CNT_LO) && idx_ok;
  assign wr_hi   = reg_we && (addr == RA_CNT_HI) && idx_ok;

  perfctr_ctrl #(
    .NUM_CTR (NUM_CTR),
    .CTR_W   (CTR_W)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl_we     (wr_ctrl),
    .idx_we      (wr_idx),
    .wdata       (reg_wdata),
    .sel_cnt     (sel_cnt),
    .en_o        (en),
    .upper_o     (ctrl_upper),
    .snap_pend_o (snap_pend),
    .idx_o       (idx),
    .idx_ok_o    (idx_ok),
    .snap_o      (snap_val)
  );

  for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
    logic hit_here;
    assign hit_here = (idx == IDX_W'(g));

    perfctr_counter #(
      .NUM_COND (NUM_COND),
      .CTR_W    (CTR_W)
    ) u_ctr (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_i   (en),
      .ev_i   (ev_in),
      .cfg_we (wr_cfg && hit_here),
      .lo_we  (wr_lo && hit_here),
      .hi_we  (wr_hi && hit_here),
      .wdata  (reg_wdata),
      .cnt_o  (cnt_all[g]),
      .cfg_o  (cfg_all[g]),
      .inc_o  (inc_all[g])
    );
  end

  // windowed selection; out-of-range index yields zero
  always_comb begin
    sel_cnt = '0;
    sel_cfg = '0;
    for (int i = 0; i < NUM_CTR; i++) begin
      if (idx == IDX_W'(i)) begin
        sel_cnt = cnt_all[i];
        sel_cfg = cfg_all[i];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (addr)
      RA_CTRL:    reg_rdata = {ctrl_upper, 14'b0, snap_pend, en};
      RA_INDEX:   reg_rdata = 32'(idx);
      RA_COND:    reg_rdata = idx_ok ? 32'(sel_cfg) : '0;
      RA_CNT_LO:  reg_rdata = sel_cnt[31:0];
      RA_CNT_HI:  reg_rdata = 32'(sel_cnt[CTR_W-1:32]);
      RA_SNAP_LO: reg_rdata = idx_ok ? snap_val[31:0] : '0;
      RA_SNAP_HI: reg_rdata = idx_ok ? 32'(snap_val[CTR_W-1:32]) : '0;
      RA_BUILD:   reg_rdata = build_word(NUM_CTR, CTR_SEL);
      default:    reg_rdata = '0;
    endcase
  end

  // R10: windowed writes with the index outside the bank touch no condition
  p_oob_cfg_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && win_addr && !idx_ok) |=> $stable(cfg_all));

  // R10: windowed reads with the index outside the bank return zero
  p_oob_read_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (win_addr && !idx_ok) |-> (reg_rdata == '0));

  // R5: no counter reports an increment while the bank is disabled
  p_no_inc_disabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (inc_all == '0));

  // R2: index register follows writes and otherwise holds
  p_index_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_idx |=> $stable(idx));

endmodule

// File: tb/test_perfctr_bank.sv
`timescale 1ns/1ps
module test_perfctr_bank;

  localparam int N  = 4;
  localparam int C  = 8;
  localparam int S  = 1;
  localparam int W  = 32 + 16 * S;
  localparam real HALF = 10.0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [C-1:0] ev = '0;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  always #(HALF) clk = ~clk;

  perfctr_bank #(.NUM_CTR(N), .NUM_COND(C), .CTR_SEL(S)) i_perfctr_bank (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_in(ev)
  );

  // reference state
  logic [W-1:0] m_cnt [N];
  logic [2:0]   m_cfg [N];
  logic         m_en, m_pend;
  logic [15:0]  m_up;
  logic [7:0]   m_idx;
  logic [W-1:0] m_snap;

  function automatic logic [31:0] exp_read(input logic [2:0] a);
    logic ok;
    ok = (m_idx < N);
    case (a)
      3'd0: return {m_up, 14'b0, m_pend, m_en};
      3'd1: return {24'b0, m_idx};
      3'd2: return ok ? {29'b0, m_cfg[m_idx[1:0]]} : 32'h0;
      3'd3: return ok ? m_cnt[m_idx[1:0]][31:0] : 32'h0;
      3'd4: return ok ? 32'(m_cnt[m_idx[1:0]][W-1:32]) : 32'h0;
      3'd5: return ok ? m_snap[31:0] : 32'h0;
      3'd6: return ok ? 32'(m_snap[W-1:32]) : 32'h0;
      default: return {14'b0, 2'(S), 8'(N), 8'h01};
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] a);
    case (a)
      3'd0: return "R9";
      3'd1, 3'd2: return "R2";
      3'd3, 3'd4: return "R6";
      3'd5, 3'd6: return "R8";
      default: return "R11";
    endcase
  endfunction

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin m_cnt[i] = '0; m_cfg[i] = '0; end
    m_en = 0; m_pend = 0; m_up = '0; m_idx = '0; m_snap = '0;
  endtask

  task automatic model_step(input logic we, input logic [2:0] a,
                            input logic [31:0] d, input logic [C-1:0] e);
    logic ok;
    ok = (m_idx < N);
    if (m_pend) m_snap = ok ? m_cnt[m_idx[1:0]] : '0;
    for (int i = 0; i < N; i++) begin
      logic sel, hit;
      sel = ok && (m_idx == 8'(i));
      hit = m_en && (m_cfg[i] != 0) && e[m_cfg[i]];
      if (we && sel && a == 3'd3)      m_cnt[i][31:0]  = d;
      else if (we && sel && a == 3'd4) m_cnt[i][W-1:32] = d[W-33:0];
      else if (hit)                    m_cnt[i] = m_cnt[i] + 1;
    end
    if (we && ok && a == 3'd2) m_cfg[m_idx[1:0]] = d[2:0];
    m_pend = we && (a == 3'd0) && d[1];
    if (we && a == 3'd0) begin m_en = d[0]; m_up = d[31:16]; end
    if (we && a == 3'd1) m_idx = d[7:0];
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  // one bus cycle; reads are checked before the edge
  task automatic cyc(input logic we, input logic [2:0] a, input logic [31:0] d,
                     input logic [C-1:0] e, input string tag);
    @(negedge clk);
    reg_we = we; reg_addr = a; reg_wdata = d; ev = e;
    #1;
    if (!we) chk(tag, reg_rdata, exp_read(a));
    @(posedge clk);
    model_step(we, a, d, e);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d, input logic [C-1:0] e);
    cyc(1'b1, a, d, e, "");
  endtask

  task automatic rd(input logic [2:0] a, input logic [C-1:0] e, input string tag);
    cyc(1'b0, a, 32'h0, e, tag);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state, R11 build word
    for (int a = 0; a < 7; a++) rd(3'(a), '0, "R1");
    rd(3'd7, '0, "R11");
    wr(3'd7, 32'hFFFF_FFFF, '0);
    rd(3'd7, '0, "R11");

    // R3: counter 0 on condition 3, line 0 pulses never count
    wr(3'd1, 0, '0);
    wr(3'd2, 3, '0);
    wr(3'd0, 1, '0);
    for (int k = 0; k < 5; k++) rd(3'd3, 8'b0000_1000, "R3");
    rd(3'd3, 8'b0000_0001, "R3");
    rd(3'd3, 8'b1111_0111, "R3");

    // R4: counter 1 left on condition 0
    wr(3'd1, 1, 8'hFF);
    for (int k = 0; k < 4; k++) rd(3'd3, 8'hFF, "R4");

    // R5: disable freezes counter 0
    wr(3'd1, 0, 8'hFF);
    wr(3'd0, 0, 8'hFF);
    for (int k = 0; k < 3; k++) rd(3'd3, 8'hFF, "R5");

    // R6: write beats same-cycle increment
    wr(3'd0, 1, 8'h08);
    wr(3'd3, 32'h0000_1234, 8'h08);
    rd(3'd3, 8'h08, "R6");
    wr(3'd4, 32'h0000_00AB, 8'h08);
    rd(3'd4, 8'h08, "R6");

    // R7: wrap of the full width
    wr(3'd3, 32'hFFFF_FFFF, 8'h00);
    wr(3'd4, 32'h0000_FFFF, 8'h00);
    rd(3'd4, 8'h08, "R7");
    rd(3'd3, 8'h00, "R7");
    rd(3'd4, 8'h00, "R7");

    // R8: capture just below the 32-bit boundary, then read torn-free halves
    wr(3'd3, 32'hFFFF_FFFE, 8'h08);
    wr(3'd4, 32'h0000_0005, 8'h08);
    wr(3'd0, 32'h0000_0003, 8'h08);
    rd(3'd0, 8'h08, "R8");
    rd(3'd0, 8'h08, "R8");
    rd(3'd3, 8'h08, "R8");
    rd(3'd5, 8'h08, "R8");
    rd(3'd4, 8'h08, "R8");
    rd(3'd6, 8'h08, "R8");

    // R9: upper control bits stored
    wr(3'd0, 32'hABCD_7FF1, 8'h00);
    rd(3'd0, 8'h00, "R9");

    // R10: index outside the bank
    wr(3'd1, 9, 8'h00);
    wr(3'd2, 5, 8'h00);
    wr(3'd3, 32'h5555_5555, 8'h00);
    for (int a = 2; a < 7; a++) rd(3'(a), 8'h00, "R10");
    rd(3'd1, 8'h00, "R2");
    wr(3'd1, 0, 8'h00);
    rd(3'd2, 8'h00, "R10");
    rd(3'd3, 8'h00, "R10");

    // seeded random traffic
    for (int k = 0; k < 4000; k++) begin
      logic [2:0]  a;
      logic [31:0] d;
      logic [C-1:0] e;
      a = 3'($urandom_range(0, 7));
      d = $urandom();
      e = C'($urandom());
      if (a == 3'd1) d = 32'($urandom_range(0, 5));
      if (a == 3'd3 && ($urandom_range(0, 3) == 0)) d = 32'hFFFF_FFF0 | (d & 32'hF);
      if ($urandom_range(0, 2) == 0) cyc(1'b1, a, d, e, "");
      else cyc(1'b0, a, 32'h0, e, tag_of(a));
    end

    done = 1;
    summary();
    $finish;
  end

endmodule